// File: doc/BRIEF.md
# Floating-Point Significand Rounder

This unit takes a normalized significand that still carries extra low-order bits below the position that will be kept, together with the result sign and a 3-bit rounding-mode code. It rounds the value to the kept width and returns three things: the rounded significand, a flag that tells the exponent logic to add one, and an inexact flag. The block sits after the add, multiply or convert datapath of a floating-point pipeline, and before exponent finalisation.

The discarded bits are reduced to a guard bit, a round bit and a sticky bit. The sticky bit is the OR of everything below the round bit. The unit then decides whether to add one to the kept magnitude. That decision depends on the selected mode, the kept least significant bit, the three reduced bits and the sign.

There is one register stage. A result appears one clock after its stimulus is accepted.

Top module: `fp_sig_rounder`

## Requirements
- R1: Mode code 000 (nearest, ties to even) increments the kept magnitude when guard=1 and round or sticky is 1. It never increments when guard=0.
- R2: In mode 000, an exact tie (guard=1, round=0, sticky=0) increments only when the kept LSB is 1. When the kept LSB is 0, the kept bits pass through unchanged.
- R3: Mode code 001 (toward zero) never increments. It outputs the kept bits unchanged and `exp_inc`=0.
- R4: Mode code 011 (toward +infinity) increments exactly when sign=0 and any discarded bit is 1.
- R5: Mode code 010 (toward -infinity) increments exactly when sign=1 and any discarded bit is 1.
- R6: Mode code 100 (nearest, ties away from zero) increments exactly when guard=1. This covers ties regardless of the kept LSB.
- R7: Codes 101, 110 and 111 set `bad_mode`=1. In that case the kept bits are output without rounding and `exp_inc`=0. Codes 000 to 100 give `bad_mode`=0.
- R8: `inexact` is 1 exactly when any discarded bit is 1, in every mode including invalid codes.
- R9: If the increment carries out of the kept width, the output is a 1 in the top bit with all other bits 0, and `exp_inc`=1. Otherwise `exp_inc`=0.
- R10: Results appear on the outputs one clock after `in_valid`=1, and `out_valid` goes to 1 in that same cycle. When `in_valid`=0, the outputs hold their values and `out_valid` is 0. Reset clears all outputs to 0.
- R11: The sticky bit is the OR of every discarded bit below the round bit. A single 1 at any of those positions has the same effect on rounding and on `inexact`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the inputs this cycle |
| in_sig | input | SIG_W+XTRA_W | Significand: kept bits on top, discarded bits at the bottom |
| in_sign | input | 1 | Result sign, 1 = negative |
| in_mode | input | 3 | Rounding-mode code |
| out_valid | output | 1 | Result valid |
| out_sig | output | SIG_W | Rounded significand |
| out_exp_inc | output | 1 | Exponent must be incremented |
| out_inexact | output | 1 | Discarded bits were nonzero |
| out_bad_mode | output | 1 | Mode code was not defined |

## Verification
Every result is due exactly one clock after the edge that accepts its stimulus. The bench therefore drives inputs on the falling edge. On the next falling edge, before it drives again, it compares all five outputs against the expectation it computed from the previous stimulus.

The reference model does not use guard, round and sticky bits. It rounds by comparing the exact discarded remainder against one half of a kept unit. Idle cycles are compared against held values. Tie, carry-out and single-sticky-position cases are driven deliberately.

// File: rtl/fp_sig_rounder.sv
module fp_sig_rounder #(
  parameter int SIG_W  = 24,
  parameter int XTRA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [SIG_W+XTRA_W-1:0] in_sig,
  input  logic                    in_sign,
  input  logic [2:0]              in_mode,
  output logic                    out_valid,
  output logic [SIG_W-1:0]        out_sig,
  output logic                    out_exp_inc,
  output logic                    out_inexact,
  output logic                    out_bad_mode
);
  localparam int TOT_W = SIG_W + XTRA_W;
  localparam logic [2:0] M_EVEN = 3'd0;
  localparam logic [2:0] M_ZERO = 3'd1;
  localparam logic [2:0] M_DOWN = 3'd2;
  localparam logic [2:0] M_UP   = 3'd3;
  localparam logic [2:0] M_AWAY = 3'd4;

  logic [SIG_W-1:0] kept;
  logic lsb, grd, rnd, stk, any_lost, bad, bump;
  logic [SIG_W:0] sum;

  assign kept = in_sig[TOT_W-1:XTRA_W];
  assign lsb  = kept[0];
  assign grd  = in_sig[XTRA_W-1];
  assign rnd  = in_sig[XTRA_W-2];

  generate
    if (XTRA_W == 3) begin : g_stk_one
      assign stk = in_sig[0];
    end else begin : g_stk_or
      assign stk = |in_sig[XTRA_W-3:0];
    end
  endgenerate

  assign any_lost = grd | rnd | stk;
  assign bad      = in_mode > M_AWAY;

  always_comb begin
    unique case (in_mode)
      M_EVEN:  bump = grd & (rnd | stk | lsb);
      M_ZERO:  bump = 1'b0;
      M_DOWN:  bump = in_sign & any_lost;
      M_UP:    bump = ~in_sign & any_lost;
      M_AWAY:  bump = grd;
      default: bump = 1'b0;
    endcase
  end

  assign sum = {1'b0, kept} + {{SIG_W{1'b0}}, bump};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_sig      <= '0;
      out_exp_inc  <= 1'b0;
      out_inexact  <= 1'b0;
      out_bad_mode <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sig      <= sum[SIG_W] ? sum[SIG_W:1] : sum[SIG_W-1:0];
        out_exp_inc  <= sum[SIG_W];
        out_inexact  <= any_lost;
        out_bad_mode <= bad;
      end
    end
  end

  AST_ZERO_MODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == M_ZERO) |=> (out_sig == $past(kept) && !out_exp_inc)); // R3
  AST_BAD_MODE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode > M_AWAY) |=> (out_bad_mode && out_sig == $past(kept) && !out_exp_inc)); // R7
  AST_INEXACT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_inexact == $past(in_sig[XTRA_W-1:0] != '0))); // R8
  AST_CARRY_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_exp_inc |-> (out_sig[SIG_W-1] && out_sig[SIG_W-2:0] == '0)); // R9
  AST_EXACT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sig[XTRA_W-1:0] == '0) |=> (out_sig == $past(kept) && !out_exp_inc)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sig) && $stable(out_exp_inc))); // R10
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_EVEN_NO_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == M_EVEN && !in_sig[XTRA_W-1]) |=> (out_sig == $past(kept))); // R1
endmodule

// File: tb/fp_sig_rounder_tb.sv
module fp_sig_rounder_tb;
  localparam int SIG_W  = 24;
  localparam int XTRA_W = 8;
  localparam int TOT_W  = SIG_W + XTRA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [TOT_W-1:0] in_sig = '0;
  logic in_sign = 1'b0;
  logic [2:0] in_mode = 3'd0;
  logic out_valid, out_exp_inc, out_inexact, out_bad_mode;
  logic [SIG_W-1:0] out_sig;

  int n_cmp = 0;
  int n_bad = 0;
  logic pending = 1'b0;
  logic e_valid = 1'b0, e_inc = 1'b0, e_inex = 1'b0, e_badm = 1'b0;
  logic [SIG_W-1:0] e_sig = '0;
  string e_tag = "R10";

  always #2 clk = ~clk;

  fp_sig_rounder #(.SIG_W(SIG_W), .XTRA_W(XTRA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sig(in_sig),
    .in_sign(in_sign), .in_mode(in_mode), .out_valid(out_valid),
    .out_sig(out_sig), .out_exp_inc(out_exp_inc), .out_inexact(out_inexact),
    .out_bad_mode(out_bad_mode));

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic compare_now();
    chk("R10", "out_valid", longint'(out_valid), longint'(e_valid));
    chk(e_tag, "out_sig", longint'(out_sig), longint'(e_sig));
    chk(e_tag, "out_exp_inc", longint'(out_exp_inc), longint'(e_inc));
    chk("R8", "out_inexact", longint'(out_inexact), longint'(e_inex));
    chk("R7", "out_bad_mode", longint'(out_bad_mode), longint'(e_badm));
  endtask

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R4";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Reference: exact remainder compared with half a unit, no guard/round/sticky split.
  task automatic step(input logic v, input logic [TOT_W-1:0] s, input logic sg,
                      input logic [2:0] m, input string tag);
    longint kept, rem, half, res;
    logic up;
    @(negedge clk);
    if (pending) compare_now();
    in_valid = v; in_sig = s; in_sign = sg; in_mode = m;
    e_valid = v;
    if (v) begin
      kept = longint'(s) >> XTRA_W;
      rem  = longint'(s) & ((64'sd1 <<< XTRA_W) - 1);
      half = 64'sd1 <<< (XTRA_W - 1);
      case (m)
        3'd0: up = (rem > half) || (rem == half && kept[0]);
        3'd1: up = 1'b0;
        3'd2: up = sg && rem != 0;
        3'd3: up = !sg && rem != 0;
        3'd4: up = rem >= half;
        default: up = 1'b0;
      endcase
      res = kept + (up ? 1 : 0);
      e_inc = res >= (64'sd1 <<< SIG_W);
      e_sig = e_inc ? SIG_W'(res >> 1) : SIG_W'(res);
      e_inex = rem != 0;
      e_badm = m > 3'd4;
      e_tag = (tag != "") ? tag : (e_inc ? "R9" : mode_tag(m));
    end
    pending = 1'b1;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [TOT_W-1:0] v;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "reset out_valid", longint'(out_valid), 0);
    chk("R10", "reset out_sig", longint'(out_sig), 0);
    chk("R10", "reset flags", longint'({out_exp_inc, out_inexact, out_bad_mode}), 0);
    rst_n = 1'b1;

    // Exhaustive LSB/G/R/S x sign x mode; R2 tie cases tagged
    for (int m = 0; m < 8; m++)
      for (int sg = 0; sg < 2; sg++)
        for (int c = 0; c < 16; c++) begin
          v = {1'b1, 23'($urandom), 8'h00};
          v[XTRA_W] = c[3];
          v[XTRA_W-1] = c[2];
          v[XTRA_W-2] = c[1];
          if (c[0]) v[$urandom_range(XTRA_W-3, 0)] = 1'b1;
          step(1'b1, v, sg[0], m[2:0], (m == 0 && c[2:0] == 3'b100) ? "R2" : "");
        end

    // R11: single sticky bit at every position below round
    for (int p = 0; p < XTRA_W - 2; p++)
      for (int m = 0; m < 5; m++) begin
        v = {24'h800002, 8'h00};
        v[XTRA_W-1] = 1'b1;
        v[p] = 1'b1;
        step(1'b1, v, 1'b0, m[2:0], "R11");
        v = {24'h800000, 8'h00};
        v[p] = 1'b1;
        step(1'b1, v, 1'b1, m[2:0], "R11");
      end

    // R9: carry out of the kept width in every mode
    for (int m = 0; m < 8; m++)
      for (int sg = 0; sg < 2; sg++)
        step(1'b1, {24'hFFFFFF, 8'hC1}, sg[0], m[2:0], "");
    step(1'b1, {24'hFFFFFF, 8'h80}, 1'b0, 3'd0, "R9");
    step(1'b1, {24'hFFFFFE, 8'h80}, 1'b0, 3'd0, "R2");

    // R10: idle cycles hold results
    step(1'b1, {24'hABCDEF, 8'h7F}, 1'b0, 3'd3, "");
    for (int i = 0; i < 4; i++) step(1'b0, TOT_W'($urandom), 1'b1, 3'd2, "R10");

    // Random patterns, random idle gaps
    for (int i = 0; i < 3000; i++)
      step(($urandom_range(7, 0) != 0), TOT_W'($urandom), 1'($urandom), 3'($urandom), "");

    step(1'b0, '0, 1'b0, 3'd0, "R10");
    @(negedge clk);
    compare_now();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule